// File: doc/BRIEF.md
# Bidirectional Latched Inverting Transceiver

This block sits between two 8-bit ports, A and B, and moves data in either direction through a bank of storage that belongs to that direction. Each bank has three active-low controls: a direction enable, a latch enable and an output enable. Data can pass straight through, be captured and held, or be driven out later from storage. It is always inverted on the way out.

The block is synchronous to one system clock. A bank is open when its direction enable and its latch enable are both low. While it is open, the bank's output view follows the incoming port combinationally. Storage reloads from the incoming port on every clock edge at which the bank is open. When either of the two controls goes high, storage keeps the value it took at the last open edge. Each output port is three-state. It is modelled as a data vector plus a per-bit drive-enable vector. A flag reports when both directions drive at the same time.

Top module: `xlat_top`

## Requirements
- R1: While `rst` is high, both drive vectors are all zero. The synchronous reset clears both storage banks to zero, so a bank read from storage right after reset shows 8'hFF on its driven port.
- R2: When `ab_en_n`, `ab_le_n` and `ab_oe_n` are all low, `b_drv` is 8'hFF and `b_out` equals `~a_in`, following changes in `a_in` within the same cycle.
- R3: Storage takes the value of the incoming port at the last clock edge at which the direction enable and the latch enable were both low. Raising either of the two freezes that value.
- R4: While the direction enable or the latch enable is high, storage does not change, whatever the incoming port does.
- R5: A port is driven (drive vector 8'hFF) only when its direction enable and its output enable are both low and reset is not active. Otherwise its drive vector and its data vector are both 8'h00.
- R6: A driven port that is not transparent shows the bitwise complement of the stored byte.
- R7: Storage still loads while the output enable is high. The port stays undriven during the load, and the loaded value appears, inverted, once the output is enabled.
- R8: The B-to-A direction (`ba_*` controls, `b_in` to `a_out`/`a_drv`) behaves like A-to-B and is independent of it.
- R9: `clash` is 1 exactly when both `a_drv` and `b_drv` are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous reset, active high |
| a_in | input | 8 | data arriving on port A |
| b_in | input | 8 | data arriving on port B |
| ab_en_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_en_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 8 | data driven onto port B |
| b_drv | output | 8 | per-bit drive enable for port B |
| a_out | output | 8 | data driven onto port A |
| a_drv | output | 8 | per-bit drive enable for port A |
| clash | output | 1 | both ports driven at once |

## Verification
The bench goes after capture through each of the two controls. A design that keyed capture on the latch enable alone would go on following the port after the direction enable rose. It tests loading while the output is off. A design that tied loading to the output enable would later show stale data. Changing the incoming data within a transparent cycle exposes a registered pass-through, which would lag by one clock. Long random runs with resets and both directions active catch a missing inversion, crossed direction controls and a wrong contention flag.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int XLAT_W    = 8;
    localparam int XLAT_DIRS = 2;

    typedef enum logic {DIR_AB = 1'b0, DIR_BA = 1'b1} xlat_dir_e;

    typedef struct packed {
        logic dir_n;
        logic le_n;
        logic oe_n;
    } xlat_ctl_t;

    function automatic logic bank_closed(xlat_ctl_t c);
        return c.dir_n | c.le_n;
    endfunction

    function automatic logic bank_drives(xlat_ctl_t c);
        return !c.dir_n && !c.oe_n;
    endfunction
endpackage

// File: rtl/xlat_bank.sv
module xlat_bank
    import xlat_pkg::*;
#(
    parameter int W = XLAT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  xlat_ctl_t    ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] view
);
    logic [W-1:0] store;
    logic         closed;

    assign closed = bank_closed(ctl);

    always_ff @(posedge clk) begin
        if (rst)
            store <= '0;
        else if (!closed)
            store <= din;
    end

    assign view = closed ? store : din;

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && closed) |-> (view == '0));
    // R3
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!closed) |=> (store == $past(din)));
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        closed |=> $stable(store));
endmodule

// File: rtl/xlat_drive.sv
module xlat_drive
    import xlat_pkg::*;
#(
    parameter int W = XLAT_W
) (
    input  logic         rst,
    input  xlat_ctl_t    ctl,
    input  logic [W-1:0] view,
    output logic [W-1:0] dout,
    output logic [W-1:0] den
);
    logic on;

    assign on   = !rst && bank_drives(ctl);
    assign den  = {W{on}};
    assign dout = on ? ~view : '0;
endmodule

// File: rtl/xlat_top.sv
module xlat_top
    import xlat_pkg::*;
#(
    parameter int W = XLAT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_en_n,
    input  logic         ab_le_n,
    input  logic         ab_oe_n,
    input  logic         ba_en_n,
    input  logic         ba_le_n,
    input  logic         ba_oe_n,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_drv,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_drv,
    output logic         clash
);
    xlat_ctl_t    ctl  [XLAT_DIRS];
    logic [W-1:0] src  [XLAT_DIRS];
    logic [W-1:0] view [XLAT_DIRS];
    logic [W-1:0] dout [XLAT_DIRS];
    logic [W-1:0] den  [XLAT_DIRS];

    assign ctl[DIR_AB] = '{dir_n: ab_en_n, le_n: ab_le_n, oe_n: ab_oe_n};
    assign ctl[DIR_BA] = '{dir_n: ba_en_n, le_n: ba_le_n, oe_n: ba_oe_n};
    assign src[DIR_AB] = a_in;
    assign src[DIR_BA] = b_in;

    for (genvar d = 0; d < XLAT_DIRS; d++) begin : g_dir
        xlat_bank #(.W(W)) u_bank (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl[d]),
            .din  (src[d]),
            .view (view[d])
        );
        xlat_drive #(.W(W)) u_drive (
            .rst  (rst),
            .ctl  (ctl[d]),
            .view (view[d]),
            .dout (dout[d]),
            .den  (den[d])
        );
    end

    assign b_out = dout[DIR_AB];
    assign b_drv = den[DIR_AB];
    assign a_out = dout[DIR_BA];
    assign a_drv = den[DIR_BA];
    assign clash = (b_drv != '0) && (a_drv != '0);

    // R2
    pass_ab_chk: assert property (@(posedge clk) disable iff (rst)
        (!ab_en_n && !ab_le_n && !ab_oe_n) |-> (b_drv == '1 && b_out == ~a_in));
    // R5
    off_b_chk: assert property (@(posedge clk) disable iff (rst)
        (ab_en_n || ab_oe_n) |-> (b_drv == '0 && b_out == '0));
    // R8
    off_a_chk: assert property (@(posedge clk) disable iff (rst)
        (ba_en_n || ba_oe_n) |-> (a_drv == '0 && a_out == '0));
    // R9
    clash_chk: assert property (@(posedge clk) disable iff (rst)
        (!ab_en_n && !ab_oe_n && !ba_en_n && !ba_oe_n) |-> clash);
endmodule

// File: tb/xlat_top_tb.sv
`timescale 1ns/1ps
module xlat_top_tb;
    logic       clk = 0;
    logic       rst;
    logic [7:0] a_in, b_in;
    logic       ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n;
    logic [7:0] b_out, b_drv, a_out, a_drv;
    logic       clash;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_ab = 8'h00;
    logic [7:0] m_ba = 8'h00;

    always #2 clk = ~clk;

    xlat_top u_dut (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
        .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n),
        .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv),
        .clash(clash)
    );

    // behavioural reference storage
    always @(posedge clk) begin
        if (rst) begin
            m_ab = 8'h00;
            m_ba = 8'h00;
        end else begin
            if (!ab_en_n && !ab_le_n) m_ab = a_in;
            if (!ba_en_n && !ba_le_n) m_ba = b_in;
        end
    end

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_cmp(string tag);
        logic [7:0] vab, vba;
        logic dab, dba;
        vab = (ab_en_n || ab_le_n) ? m_ab : a_in;
        vba = (ba_en_n || ba_le_n) ? m_ba : b_in;
        dab = !rst && !ab_en_n && !ab_oe_n;
        dba = !rst && !ba_en_n && !ba_oe_n;
        chk({tag, " R5 b_drv"}, b_drv, {8{dab}});
        chk({tag, " R6 b_out"}, b_out, dab ? ~vab : 8'h00);
        chk({tag, " R8 a_drv"}, a_drv, {8{dba}});
        chk({tag, " R8 a_out"}, a_out, dba ? ~vba : 8'h00);
        chk({tag, " R9 clash"}, {7'd0, clash}, {7'd0, dab && dba});
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        @(negedge clk);
        model_cmp(tag);
    endtask

    task automatic ab(logic e, logic l, logic o);
        ab_en_n = e; ab_le_n = l; ab_oe_n = o;
    endtask

    task automatic ba(logic e, logic l, logic o);
        ba_en_n = e; ba_le_n = l; ba_oe_n = o;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; a_in = 8'h00; b_in = 8'h00;
        ab(0, 1, 0); ba(0, 1, 0);
        tick("R1 reset");
        chk("R1 b_drv in reset", b_drv, 8'h00);
        chk("R1 a_drv in reset", a_drv, 8'h00);
        rst = 0;
        #1;
        chk("R1 cleared AB store", b_out, 8'hFF);
        chk("R1 cleared BA store", a_out, 8'hFF);
        ba(1, 1, 1);

        // R2 transparent path, combinational follow
        ab(0, 0, 0); a_in = 8'h3C;
        tick("R2");
        chk("R2 transparent", b_out, 8'hC3);
        a_in = 8'h5A; #1;
        chk("R2 same-cycle follow", b_out, 8'hA5);

        // R3 capture via latch enable, R4 hold
        a_in = 8'hA5;
        tick("R3");
        ab_le_n = 1; a_in = 8'h0F; #1;
        chk("R3 capture via le", b_out, 8'h5A);
        tick("R4");
        a_in = 8'hF0;
        tick("R4");
        chk("R4 hold", b_out, 8'h5A);

        // R3 capture via direction enable
        ab(0, 0, 0); a_in = 8'h66;
        tick("R3");
        ab_en_n = 1; a_in = 8'h11;
        tick("R5");
        chk("R5 off when dir high", b_drv, 8'h00);
        ab(0, 1, 0);
        tick("R3");
        chk("R3 capture via dir", b_out, 8'h99);

        // R7 load while output disabled
        ab(0, 0, 1); a_in = 8'hC8;
        tick("R7");
        chk("R7 undriven during load", b_drv, 8'h00);
        chk("R7 data zero during load", b_out, 8'h00);
        ab_en_n = 1;
        tick("R7");
        a_in = 8'h00; ab(0, 1, 0);
        tick("R7");
        chk("R7 loaded value shown", b_out, 8'h37);

        // R8 reverse direction
        ab(1, 1, 1);
        ba(0, 0, 0); b_in = 8'h81;
        tick("R8");
        chk("R8 transparent B to A", a_out, 8'h7E);
        ba_le_n = 1; b_in = 8'h00;
        tick("R8");
        chk("R8 hold B to A", a_out, 8'h7E);
        chk("R8 A to B untouched", b_drv, 8'h00);

        // R9 contention
        ab(0, 1, 0);
        tick("R9");
        chk("R9 clash set", {7'd0, clash}, 8'h01);
        ab_oe_n = 1;
        tick("R9");
        chk("R9 clash clear", {7'd0, clash}, 8'h00);

        // random traffic in both directions
        for (int i = 0; i < 3000; i++) begin
            rst = ($urandom_range(0, 63) == 0);
            a_in = 8'($urandom);
            b_in = 8'($urandom);
            ab(1'($urandom), 1'($urandom), 1'($urandom));
            ba(1'($urandom), 1'($urandom), 1'($urandom));
            tick("random R3 R4");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule